// File: doc/BRIEF.md
# DMA channel start and result unit

This unit holds the per-channel control and status state that sits in front of a shared descriptor executor. Software starts a channel by writing a command pointer: an 8-byte-aligned byte address shifted right by three. The unit reads the pointer list entry found there. When the entry names a command list, the unit hands that list's address to the executor. It keeps walking the list of 32-bit entries until it reaches the one marked last. When the walk ends, the unit posts a result word for the channel. The walk ends on success, on an error, or on a flush.

All channels share one word-addressed register port. A register address is `{select[2:0], channel}`, and the select codes are stated in the requirements. Busy channels share the pointer fetch port and the executor. The unit serves them one walk at a time, in round-robin order. Each posted result can set the channel's bit in an aggregate interrupt status word. A single interrupt line is the OR of those bits. Reading the result register acknowledges the result.

Top module: `dmactl_chan_unit`

## Requirements
- R1: A write to select 0 (command pointer) of an idle channel stores wdata[28:0] and marks the channel busy. The unit then issues `mem_req` with `mem_addr` = stored value << 3.
- R2: A fetched entry with bit 29 set starts the executor for one cycle, with `exe_list_addr` = entry[28:0] << 3 and `exe_ch` = the channel. An entry with bit 29 clear does not start the executor. It posts result 0x8000_0008 (valid bit 31, error bit 3).
- R3: When the executor finishes without error, the next step depends on entry bit 31. If bit 31 is set, the unit posts result 0x8000_0002 (valid bit 31, pointer-list-done bit 1). If bit 31 is clear, the next entry is fetched at the previous entry address + 4. Only one fetch is outstanding at a time.
- R4: An executor error posts 0x8000_0008 and stops the walk with no further fetch.
- R5: A write to select 2 (flush) acts only on a busy channel:
  - If the channel is executing, `exe_abort` pulses.
  - If the channel is only queued, it is dropped unexecuted.
  - In both cases, if bit 1 of the channel's result config is set, result 0x8000_0004 (valid bit 31, flushed bit 2) is posted. If that bit is clear, the channel goes idle with nothing posted.
  - A flush to an idle channel has no effect.
- R6: A read of select 1 (result) returns the stored word. The same read clears the stored word, the pending status and the channel's aggregate interrupt bit.
- R7: Select 4 (result config) is read/write, 2 bits wide. When a result is posted while bit 0 is set, bit `ch` of select 5 (aggregate interrupt status) is set. `irq` is the OR of the aggregate bits.
- R8: A command pointer write to a busy channel is ignored. A read of select 0 returns the stored pointer.
- R9: Busy channels are served in round-robin order, starting after the channel served last.
- R10: A read of select 3 (status) returns pending in bit 1 and busy in bit 0. Both are zero after reset. Read data appears on `reg_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3+log2(NUM_CH) | {select, channel} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| mem_req | output | 1 | Pointer entry fetch request |
| mem_addr | output | 32 | Byte address of the entry |
| mem_rvalid | input | 1 | Fetch data valid |
| mem_rdata | input | 32 | Fetched pointer entry |
| exe_start | output | 1 | Start the executor on a command list |
| exe_list_addr | output | 32 | Command list byte address |
| exe_ch | output | log2(NUM_CH) | Channel being executed |
| exe_abort | output | 1 | Abort the running command list |
| exe_done | input | 1 | Executor finished the list |
| exe_err | input | 1 | Executor finished with an error (with exe_done) |
| irq | output | 1 | Interrupt, OR of aggregate status bits |

## Verification
The bench builds the unit with NUM_CH = 4, so the channel field is two bits and every channel can be driven by hand. It sweeps every channel against all four result-config values and against walks of one and two entries. Expected fetch addresses, list addresses, result words and aggregate bits are computed from the channel and configuration indices. The small channel count also makes every round-robin wrap reachable. One case shows that the served order differs from fixed priority. Flush cases cover a channel that is executing, a channel that is only queued and an idle channel.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    typedef logic [31:0] word_t;

    // result word flags
    localparam int RES_VALID = 31;
    localparam int RES_ERR   = 3;
    localparam int RES_FLUSH = 2;
    localparam int RES_TPD   = 1;

    // pointer list entry flags
    localparam int ENT_LAST  = 31;
    localparam int ENT_LIST  = 29;
    localparam int PTR_W     = 29;

    // result config bits
    localparam int CONF_IRQ   = 0;
    localparam int CONF_FLUSH = 1;
    localparam int CONF_W     = 2;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMDPTR  = 3'd0,
        SEL_RESULT  = 3'd1,
        SEL_FLUSH   = 3'd2,
        SEL_STATUS  = 3'd3,
        SEL_RCONF   = 3'd4,
        SEL_IRQSTAT = 3'd5
    } reg_sel_e;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_WAIT,
        ENG_ISSUE,
        ENG_EXEC,
        ENG_DONE
    } eng_state_e;

    typedef enum logic [1:0] {
        END_OK,
        END_ERR,
        END_FLUSH
    } end_kind_e;

    function automatic word_t make_result(end_kind_e kind);
        word_t w;
        w = '0;
        w[RES_VALID] = 1'b1;
        case (kind)
            END_OK:    w[RES_TPD]   = 1'b1;
            END_ERR:   w[RES_ERR]   = 1'b1;
            default:   w[RES_FLUSH] = 1'b1;
        endcase
        return w;
    endfunction

    function automatic word_t ptr_to_byte(logic [PTR_W-1:0] p);
        return {p, 3'b000};
    endfunction

endpackage

// File: rtl/dmactl_rr_pick.sv
module dmactl_rr_pick #(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    input  logic [CH_W-1:0]   last,
    output logic              any,
    output logic [CH_W-1:0]   pick
);
    // offsets 1..NUM_CH after the last grant; smallest offset wins
    always_comb begin
        any  = 1'b0;
        pick = last;
        for (int off = NUM_CH; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % NUM_CH;
            if (req[idx]) begin
                any  = 1'b1;
                pick = idx[CH_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dmactl_chan_ctx.sv
module dmactl_chan_ctx
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ptr,
    input  logic              wr_flush,
    input  logic              wr_conf,
    input  logic              rd_result,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic [CONF_W-1:0] conf_wdata,
    input  logic              active,
    input  logic              post_valid,
    input  word_t             post_word,
    output logic              busy,
    output logic [PTR_W-1:0]  ptr_q,
    output word_t             result_q,
    output logic              pending,
    output logic [CONF_W-1:0] conf_q,
    output logic              agg
);
    logic  eng_fin;
    logic  drop_fin;
    logic  fin;
    word_t fin_word;
    logic  keep;

    assign eng_fin  = post_valid && active;
    assign drop_fin = wr_flush && busy && !active;
    assign fin      = eng_fin || drop_fin;
    assign fin_word = eng_fin ? post_word : make_result(END_FLUSH);
    assign keep     = !(fin_word[RES_FLUSH] && !conf_q[CONF_FLUSH]);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            ptr_q    <= '0;
            result_q <= '0;
            pending  <= 1'b0;
            conf_q   <= '0;
            agg      <= 1'b0;
        end else begin
            if (wr_conf) begin
                conf_q <= conf_wdata;
            end
            if (wr_ptr && !busy) begin
                busy  <= 1'b1;
                ptr_q <= ptr_wdata;
            end
            if (fin) begin
                busy <= 1'b0;
            end
            if (fin && keep) begin
                result_q <= fin_word;
                pending  <= 1'b1;
                agg      <= conf_q[CONF_IRQ];
            end else if (rd_result) begin
                result_q <= '0;
                pending  <= 1'b0;
                agg      <= 1'b0;
            end
        end
    end

    p_busy_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr && busy) |=> $stable(ptr_q));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_result && !fin) |=> !pending);

    p_agg_needs_pend_r7: assert property (@(posedge clk) disable iff (rst)
        agg |-> pending);

    p_post_frees_r3: assert property (@(posedge clk) disable iff (rst)
        eng_fin |=> !busy);

endmodule

// File: rtl/dmactl_walker.sv
module dmactl_walker
    import dmactl_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] req,
    output logic [CH_W-1:0]   pick_ch,
    input  logic [PTR_W-1:0]  pick_ptr,
    input  logic              flush_wr,
    input  logic [CH_W-1:0]   flush_ch,
    output logic              act_valid,
    output logic [CH_W-1:0]   act_ch,
    output logic              mem_req,
    output word_t             mem_addr,
    input  logic              mem_rvalid,
    input  word_t             mem_rdata,
    output logic              exe_start,
    output word_t             exe_list_addr,
    output logic [CH_W-1:0]   exe_ch,
    output logic              exe_abort,
    input  logic              exe_done,
    input  logic              exe_err,
    output logic              post_valid,
    output word_t             post_word
);
    eng_state_e      state;
    logic [CH_W-1:0] last_ch;
    word_t           ptr_addr;
    word_t           entry_q;
    logic            flush_pend;
    end_kind_e       end_kind;
    logic            pick_any;
    logic            flush_hit;
    logic            unused_entry_bits;

    dmactl_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req  (req),
        .last (last_ch),
        .any  (pick_any),
        .pick (pick_ch)
    );

    assign unused_entry_bits = ^{entry_q[30], mem_rdata[0]};

    assign flush_hit = flush_wr && (flush_ch == act_ch) &&
                       (state inside {ENG_FETCH, ENG_WAIT, ENG_ISSUE, ENG_EXEC});

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            last_ch    <= CH_W'(NUM_CH - 1);
            act_ch     <= '0;
            ptr_addr   <= '0;
            entry_q    <= '0;
            flush_pend <= 1'b0;
            end_kind   <= END_OK;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (pick_any) begin
                        act_ch     <= pick_ch;
                        last_ch    <= pick_ch;
                        ptr_addr   <= ptr_to_byte(pick_ptr);
                        flush_pend <= 1'b0;
                        state      <= ENG_FETCH;
                    end
                end
                ENG_FETCH: begin
                    if (flush_hit) flush_pend <= 1'b1;
                    state <= ENG_WAIT;
                end
                ENG_WAIT: begin
                    if (mem_rvalid) begin
                        if (flush_pend || flush_hit) begin
                            end_kind <= END_FLUSH;
                            state    <= ENG_DONE;
                        end else begin
                            entry_q <= mem_rdata;
                            state   <= ENG_ISSUE;
                        end
                    end else if (flush_hit) begin
                        flush_pend <= 1'b1;
                    end
                end
                ENG_ISSUE: begin
                    if (flush_hit) begin
                        end_kind <= END_FLUSH;
                        state    <= ENG_DONE;
                    end else if (!entry_q[ENT_LIST]) begin
                        end_kind <= END_ERR;
                        state    <= ENG_DONE;
                    end else begin
                        state <= ENG_EXEC;
                    end
                end
                ENG_EXEC: begin
                    if (flush_hit) begin
                        end_kind <= END_FLUSH;
                        state    <= ENG_DONE;
                    end else if (exe_done) begin
                        if (exe_err) begin
                            end_kind <= END_ERR;
                            state    <= ENG_DONE;
                        end else if (entry_q[ENT_LAST]) begin
                            end_kind <= END_OK;
                            state    <= ENG_DONE;
                        end else begin
                            ptr_addr <= ptr_addr + 32'd4;
                            state    <= ENG_FETCH;
                        end
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign act_valid     = (state != ENG_IDLE);
    assign mem_req       = (state == ENG_FETCH);
    assign mem_addr      = ptr_addr;
    assign exe_start     = (state == ENG_ISSUE) && !flush_hit && entry_q[ENT_LIST];
    assign exe_list_addr = ptr_to_byte(entry_q[PTR_W-1:0]);
    assign exe_ch        = act_ch;
    assign exe_abort     = (state == ENG_EXEC) && flush_hit;
    assign post_valid    = (state == ENG_DONE);
    assign post_word     = make_result(end_kind);

    p_start_abort_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(exe_start && exe_abort));

    p_abort_posts_r5: assert property (@(posedge clk) disable iff (rst)
        exe_abort |=> post_valid);

    p_single_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        exe_start |=> !exe_start);

endmodule

// File: rtl/dmactl_chan_unit.sv
module dmactl_chan_unit
    import dmactl_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = SEL_W + CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              exe_start,
    output logic [31:0]       exe_list_addr,
    output logic [CH_W-1:0]   exe_ch,
    output logic              exe_abort,
    input  logic              exe_done,
    input  logic              exe_err,
    output logic              irq
);
    reg_sel_e          sel;
    logic [CH_W-1:0]   ch;
    logic [NUM_CH-1:0] wr_ptr_v, wr_flush_v, wr_conf_v, rd_res_v;
    logic [NUM_CH-1:0] busy_v, pend_v, agg_v, active_v, req_v;
    logic [PTR_W-1:0]  ptr_arr  [NUM_CH];
    word_t             res_arr  [NUM_CH];
    logic [CONF_W-1:0] conf_arr [NUM_CH];
    logic              act_valid;
    logic [CH_W-1:0]   act_ch;
    logic [CH_W-1:0]   pick_ch;
    logic              post_valid;
    word_t             post_word;
    logic              flush_wr;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(reg_addr[ADDR_W-1:CH_W]);
    assign ch           = reg_addr[CH_W-1:0];
    assign flush_wr     = reg_wr && (sel == SEL_FLUSH);
    assign unused_wdata = ^reg_wdata[31:PTR_W];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign wr_ptr_v[i]   = reg_wr && (sel == SEL_CMDPTR) && (ch == CH_W'(i));
        assign wr_flush_v[i] = flush_wr && (ch == CH_W'(i));
        assign wr_conf_v[i]  = reg_wr && (sel == SEL_RCONF) && (ch == CH_W'(i));
        assign rd_res_v[i]   = reg_rd && (sel == SEL_RESULT) && (ch == CH_W'(i));
        assign active_v[i]   = act_valid && (act_ch == CH_W'(i));

        dmactl_chan_ctx u_ctx (
            .clk        (clk),
            .rst        (rst),
            .wr_ptr     (wr_ptr_v[i]),
            .wr_flush   (wr_flush_v[i]),
            .wr_conf    (wr_conf_v[i]),
            .rd_result  (rd_res_v[i]),
            .ptr_wdata  (reg_wdata[PTR_W-1:0]),
            .conf_wdata (reg_wdata[CONF_W-1:0]),
            .active     (active_v[i]),
            .post_valid (post_valid),
            .post_word  (post_word),
            .busy       (busy_v[i]),
            .ptr_q      (ptr_arr[i]),
            .result_q   (res_arr[i]),
            .pending    (pend_v[i]),
            .conf_q     (conf_arr[i]),
            .agg        (agg_v[i])
        );
    end

    // a channel being dropped by a flush this cycle must not be picked
    assign req_v = busy_v & ~wr_flush_v;

    dmactl_walker #(.NUM_CH(NUM_CH)) u_walk (
        .clk           (clk),
        .rst           (rst),
        .req           (req_v),
        .pick_ch       (pick_ch),
        .pick_ptr      (ptr_arr[pick_ch]),
        .flush_wr      (flush_wr),
        .flush_ch      (ch),
        .act_valid     (act_valid),
        .act_ch        (act_ch),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .exe_start     (exe_start),
        .exe_list_addr (exe_list_addr),
        .exe_ch        (exe_ch),
        .exe_abort     (exe_abort),
        .exe_done      (exe_done),
        .exe_err       (exe_err),
        .post_valid    (post_valid),
        .post_word     (post_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (sel)
                SEL_CMDPTR:  reg_rdata <= word_t'(ptr_arr[ch]);
                SEL_RESULT:  reg_rdata <= res_arr[ch];
                SEL_STATUS:  reg_rdata <= {30'd0, pend_v[ch], busy_v[ch]};
                SEL_RCONF:   reg_rdata <= word_t'(conf_arr[ch]);
                SEL_IRQSTAT: reg_rdata <= word_t'(agg_v);
                default:     reg_rdata <= '0;
            endcase
        end
    end

    assign irq = |agg_v;

endmodule

// File: tb/tb_dmactl_chan_unit.sv
module tb_dmactl_chan_unit;
    localparam int NCH = 4;
    localparam int CW  = 2;
    localparam int AW  = 5;
    localparam int EXE_LAT = 4;

    localparam logic [2:0] S_PTR = 3'd0, S_RES = 3'd1, S_FL = 3'd2,
                           S_ST = 3'd3, S_CONF = 3'd4, S_IRQ = 3'd5;
    localparam logic [31:0] RES_OK  = 32'h8000_0002;
    localparam logic [31:0] RES_ERR = 32'h8000_0008;
    localparam logic [31:0] RES_FLU = 32'h8000_0004;
    localparam logic [31:0] E_CMD   = 32'h2000_0000;
    localparam logic [31:0] E_LAST  = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst;
    logic reg_wr, reg_rd;
    logic [AW-1:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic exe_start, exe_abort, exe_done, exe_err;
    logic [31:0] exe_list_addr;
    logic [CW-1:0] exe_ch;
    logic irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dmactl_chan_unit #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .exe_start(exe_start),
        .exe_list_addr(exe_list_addr), .exe_ch(exe_ch), .exe_abort(exe_abort),
        .exe_done(exe_done), .exe_err(exe_err), .irq(irq)
    );

    // pointer memory model: two-cycle read latency
    logic [31:0] mem [0:255];
    logic        p1v, p2v;
    logic [31:0] p1a, p2a;
    logic [31:0] mem_log [0:1023];
    int          mem_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            p1v <= 1'b0;
            p2v <= 1'b0;
        end else begin
            p1v <= mem_req;
            p2v <= p1v;
        end
        p1a <= mem_addr;
        p2a <= p1a;
        if (!rst && mem_req) begin
            mem_log[mem_n] <= mem_addr;
            mem_n <= mem_n + 1;
        end
    end
    assign mem_rvalid = p2v;
    assign mem_rdata  = mem[p2a[9:2]];

    // executor model
    int          cnt = 0;
    logic [31:0] cur_addr = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] exe_log [0:1023];
    int          exe_chl [0:1023];
    int          exe_n = 0;
    int          abort_n = 0;

    always @(posedge clk) begin
        if (rst) begin
            cnt <= 0;
        end else if (exe_abort) begin
            cnt <= 0;
            abort_n <= abort_n + 1;
        end else if (exe_start) begin
            cnt <= EXE_LAT;
            cur_addr <= exe_list_addr;
            exe_log[exe_n] <= exe_list_addr;
            exe_chl[exe_n] <= int'(exe_ch);
            exe_n <= exe_n + 1;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end
    end
    assign exe_done = (cnt == 1);
    assign exe_err  = exe_done && (cur_addr == err_addr);

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input int c, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = {s, c[CW-1:0]};
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input int c, output logic [31:0] d);
        @(negedge clk);
        reg_rd   = 1'b1;
        reg_addr = {s, c[CW-1:0]};
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_pend(input int c);
        logic [31:0] d;
        for (int k = 0; k < 300; k++) begin
            rd(S_ST, c, d);
            if (d[1]) return;
        end
    endtask

    task automatic build_list(input int base, input int n, input logic [31:0] cmd0);
        for (int i = 0; i < n; i++) begin
            logic [31:0] e;
            e = E_CMD | ((cmd0 + 32'(i) * 32'h100) >> 3);
            if (i == n - 1) e = e | E_LAST;
            mem[(base >> 2) + i] = e;
        end
    endtask

    initial begin
        logic [31:0] d;
        int mb, eb, ab;

        for (int i = 0; i < 256; i++) mem[i] = '0;
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state
        for (int c = 0; c < NCH; c++) begin
            rd(S_ST, c, d);
            check("R10 reset status", d, 32'd0);
        end
        rd(S_IRQ, 0, d);
        check("R7 reset aggregate", d, 32'd0);
        check("R7 reset irq", {31'd0, irq}, 32'd0);

        // sweep: channel x result config x walk length
        for (int c = 0; c < NCH; c++) begin
            for (int cf = 0; cf < 4; cf++) begin
                for (int n = 1; n <= 2; n++) begin
                    int base;
                    logic [31:0] cmd0;
                    base = 32'h200 + c * 32'h20;
                    cmd0 = 32'h1_0000 * 32'(c + 1) + 32'h1000 * 32'(cf) + 32'h800 * 32'(n);
                    mb = mem_n; eb = exe_n;
                    wr(S_CONF, c, 32'(cf));
                    build_list(base, n, cmd0);
                    wr(S_PTR, c, 32'(base) >> 3);
                    wait_pend(c);
                    check("R3 walk length", 32'(exe_n - eb), 32'(n));
                    for (int i = 0; i < n; i++) begin
                        check("R1 entry fetch address", mem_log[mb + i], 32'(base) + 32'(4 * i));
                        check("R2 list address", exe_log[eb + i], cmd0 + 32'(i) * 32'h100);
                        check("R2 executor channel", 32'(exe_chl[eb + i]), 32'(c));
                    end
                    rd(S_ST, c, d);
                    check("R10 pending not busy", d, 32'd2);
                    check("R7 irq follows enable", {31'd0, irq}, 32'(cf & 1));
                    rd(S_IRQ, 0, d);
                    check("R7 aggregate bit", d, 32'(cf & 1) << c);
                    rd(S_CONF, c, d);
                    check("R7 config readback", d, 32'(cf));
                    rd(S_RES, c, d);
                    check("R3 result done", d, RES_OK);
                    rd(S_ST, c, d);
                    check("R6 status cleared", d, 32'd0);
                    check("R6 irq cleared", {31'd0, irq}, 32'd0);
                    rd(S_RES, c, d);
                    check("R6 result cleared", d, 32'd0);
                end
            end
        end

        // entry without the command-list flag
        eb = exe_n;
        mem[32'h300 >> 2] = E_LAST | 32'h0000_1234;
        wr(S_CONF, 1, 32'd1);
        wr(S_PTR, 1, 32'h300 >> 3);
        wait_pend(1);
        rd(S_RES, 1, d);
        check("R2 bad entry error", d, RES_ERR);
        check("R2 no executor start", 32'(exe_n - eb), 32'd0);

        // executor error on the second of three lists
        eb = exe_n; mb = mem_n;
        build_list(32'h300, 3, 32'h5_0000);
        err_addr = 32'h5_0100;
        wr(S_PTR, 2, 32'h300 >> 3);
        wait_pend(2);
        rd(S_RES, 2, d);
        check("R4 executor error", d, RES_ERR);
        check("R4 stops executing", 32'(exe_n - eb), 32'd2);
        check("R4 stops fetching", 32'(mem_n - mb), 32'd2);
        err_addr = 32'hFFFF_FFFF;

        // flush while executing, reporting enabled
        eb = exe_n; ab = abort_n;
        build_list(32'h300, 2, 32'h6_0000);
        wr(S_CONF, 3, 32'd3);
        wr(S_PTR, 3, 32'h300 >> 3);
        for (int k = 0; k < 100 && exe_n == eb; k++) @(negedge clk);
        wr(S_FL, 3, 32'd0);
        wait_pend(3);
        rd(S_RES, 3, d);
        check("R5 flushed result", d, RES_FLU);
        check("R5 abort issued", 32'(abort_n - ab), 32'd1);
        check("R5 walk cut short", 32'(exe_n - eb), 32'd1);

        // flush while executing, reporting disabled
        eb = exe_n; ab = abort_n;
        wr(S_CONF, 3, 32'd1);
        wr(S_PTR, 3, 32'h300 >> 3);
        for (int k = 0; k < 100 && exe_n == eb; k++) @(negedge clk);
        wr(S_FL, 3, 32'd0);
        repeat (20) @(negedge clk);
        rd(S_ST, 3, d);
        check("R5 silent flush idle", d, 32'd0);
        check("R5 silent flush irq", {31'd0, irq}, 32'd0);
        check("R5 silent abort", 32'(abort_n - ab), 32'd1);

        // flush of an idle channel
        wr(S_CONF, 0, 32'd3);
        wr(S_FL, 0, 32'd0);
        repeat (5) @(negedge clk);
        rd(S_ST, 0, d);
        check("R5 idle flush no effect", d, 32'd0);

        // write to a busy channel ignored
        mb = mem_n;
        build_list(32'h340, 3, 32'h7_0000);
        build_list(32'h380, 1, 32'h8_0000);
        wr(S_PTR, 0, 32'h340 >> 3);
        wr(S_PTR, 0, 32'h380 >> 3);
        wait_pend(0);
        check("R8 fetch count", 32'(mem_n - mb), 32'd3);
        for (int i = 0; i < 3; i++)
            check("R8 first list kept", mem_log[mb + i], 32'h340 + 32'(4 * i));
        rd(S_PTR, 0, d);
        check("R8 pointer readback", d, 32'h340 >> 3);
        rd(S_RES, 0, d);
        check("R8 result", d, RES_OK);

        // round robin: ch2 running, then 0, 1, 3 queued
        eb = exe_n;
        build_list(32'h300, 3, 32'h9_0000);
        build_list(32'h3C0, 1, 32'hA_0000);
        for (int c = 0; c < NCH; c++) wr(S_CONF, c, 32'd1);
        wr(S_PTR, 2, 32'h300 >> 3);
        wr(S_PTR, 0, 32'h3C0 >> 3);
        wr(S_PTR, 1, 32'h3C0 >> 3);
        wr(S_PTR, 3, 32'h3C0 >> 3);
        for (int c = 0; c < NCH; c++) wait_pend(c);
        check("R9 served count", 32'(exe_n - eb), 32'd6);
        check("R9 order 0", 32'(exe_chl[eb + 0]), 32'd2);
        check("R9 order 3", 32'(exe_chl[eb + 3]), 32'd3);
        check("R9 order 4", 32'(exe_chl[eb + 4]), 32'd0);
        check("R9 order 5", 32'(exe_chl[eb + 5]), 32'd1);
        for (int c = 0; c < NCH; c++) begin
            rd(S_RES, c, d);
            check("R9 result", d, RES_OK);
        end

        // flush of a queued channel
        eb = exe_n;
        wr(S_CONF, 1, 32'd3);
        wr(S_PTR, 2, 32'h300 >> 3);
        wr(S_PTR, 1, 32'h3C0 >> 3);
        wr(S_FL, 1, 32'd0);
        rd(S_ST, 1, d);
        check("R5 queued flush status", d, 32'd2);
        rd(S_RES, 1, d);
        check("R5 queued flush result", d, RES_FLU);
        wait_pend(2);
        rd(S_RES, 2, d);
        check("R5 running channel result", d, RES_OK);
        check("R5 queued never executed", 32'(exe_n - eb), 32'd3);
        for (int i = 0; i < 3; i++)
            check("R5 only ch2 executed", 32'(exe_chl[eb + i]), 32'd2);

        finish_run();
    end

endmodule